// File: doc/BRIEF.md
# Locked-Read Unsupported-Request Responder

This block sits on the receive side of a packet transaction layer. It watches a stream of 128-bit request headers. Each header comes with one data word and a malformed-marker bit. When a header is a locked memory read, the block does not execute it. It answers with a zero-length locked completion that carries Unsupported Request status. In the same step it raises a one-cycle error-log pulse that carries the offending header. A locked read whose malformed marker is set is dropped: the error is still logged, but no completion is built. Every other header, including one whose format says it carries data, is passed to a forward port unchanged, together with its data word and marker.

The header is one vector, `hdr[127:0]`, with dword 0 in bits [127:96], dword 1 in [95:64], dword 2 in [63:32] and dword 3 in [31:0]. Bit k of dword n is therefore `hdr[32*(3-n)+k]`.

All three streams use valid/ready handshakes. A transfer happens on a rising clock edge where valid and ready are both high. A source holds its valid and payload steady until that transfer happens. The request port is ready only when no completion is pending. When no completion is pending, a locked read is always accepted, and any other header is accepted only when the forward port is ready. Only one completion is held at a time. It stays on the completion port, unchanged, until the consumer takes it, so back-pressure on the completion port stalls the whole request stream.

Top module: `lkrd_ur_responder`

## Requirements
- R1: While reset is held low, `cpl_valid` and `err_valid` are 0.
- R2: A header is a locked read when Fmt (dword 0 bits [30:29], `hdr[126:125]`) is 2'b00 (3-dword, no data) or 2'b01 (4-dword, no data), and Type (dword 0 bits [28:24], `hdr[124:120]`) is 5'b00001. Every other header is offered on the forward port in the same cycle, unchanged, with its data word and marker: `fwd_valid` = `req_valid`, and `req_ready` = `fwd_ready`, as long as no completion is pending.
- R3: Completion dword 0 has Fmt 2'b00 and Type 5'b01011. It copies TC (bits [22:20]) and Attr (bits [13:12]) from the request. TD (bit 15), EP (bit 14) and Length (bits [9:0]) are all 0, even when the request had TD or EP set. All other dword 0 bits are 0.
- R4: Completion dword 1 has the completer ID (bits [31:16]) at 0, status (bits [15:13]) at 3'b001, BCM (bit 12) at 0, and byte count (bits [11:0]) at 4. These values do not depend on the request's length, byte enables or address.
- R5: Completion dword 2 carries the request's requester ID (request dword 1 bits [31:16]) in bits [31:16] and its tag (request dword 1 bits [15:8]) in bits [15:8]. Bit 7 and the lower address (bits [6:0]) are 0. Dword 3 is all zero.
- R6: An accepted, unmarked locked read makes `cpl_valid` high in the next cycle. `cpl_valid` and `cpl_hdr` then stay unchanged until the cycle of the `cpl_ready` handshake, and `cpl_valid` falls after that edge.
- R7: While a completion is pending, `req_ready` and `fwd_valid` are 0 for every kind of header.
- R8: Each accepted locked read causes exactly one `err_valid` cycle, in the cycle after acceptance. `err_hdr` in that cycle equals the full request header.
- R9: A locked read with `req_abort` high is accepted and logged as in R8, but no completion is produced, and the request port stays ready.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request header offered |
| req_ready | output | 1 | Request header can be taken |
| req_hdr | input | 128 | Request header, dword 0 in the top bits |
| req_data | input | DATA_W | Data word that travels with the header |
| req_abort | input | 1 | Malformed marker for this request |
| cpl_valid | output | 1 | Completion header offered |
| cpl_ready | input | 1 | Completion consumer takes the header |
| cpl_hdr | output | 128 | Completion header |
| fwd_valid | output | 1 | Non-locked header offered downstream |
| fwd_ready | input | 1 | Downstream takes the forwarded header |
| fwd_hdr | output | 128 | Forwarded header |
| fwd_data | output | DATA_W | Forwarded data word |
| fwd_abort | output | 1 | Forwarded malformed marker |
| err_valid | output | 1 | One-cycle Unsupported Request log event |
| err_hdr | output | 128 | Header of the rejected request |

## Verification
Locked reads are sent in both the 3-dword and the 4-dword format. They carry TD and EP set, extreme lengths, different byte enables and high addresses, which shows that only TC, Attr, requester ID and tag reach the completion. Some headers look almost like a locked read: a data-carrying format with the locked type code, a plain memory read, and a memory write. Each must be forwarded and not answered. These cases separate type decoding from format decoding. A completion held back for several cycles while a forward header waits behind it checks the single pending slot and the stall. Aborted locked reads mixed with good ones show that logging and completion are separate events. A long run with random back-pressure on both output ports covers the remaining handshake orderings.

// File: rtl/lkur_pkg.sv
package lkur_pkg;
  localparam int HDR_W = 128;

  // dword 0 field positions (dword 0 occupies hdr[127:96])
  localparam int P_FMT  = 125;
  localparam int P_TYPE = 120;
  localparam int P_TC   = 116;
  localparam int P_ATTR = 108;
  // request dword 1 fields
  localparam int P_RID  = 80;
  localparam int P_TAG  = 72;
  // completion dword 1 fields
  localparam int P_STAT = 77;
  localparam int P_BCNT = 64;
  localparam int P_LEN  = 96;

  localparam logic [1:0] FMT_ND3 = 2'b00;
  localparam logic [1:0] FMT_ND4 = 2'b01;
  localparam logic [4:0] TY_MRD_LOCK = 5'b00001;
  localparam logic [4:0] TY_CPL_LOCK = 5'b01011;
  localparam logic [2:0] STAT_UNSUP  = 3'b001;
endpackage

// File: rtl/lkur_classify.sv
module lkur_classify
  import lkur_pkg::*;
#(
  parameter int N_FMT = 2
) (
  input  logic [1:0] fmt,
  input  logic [4:0] ttype,
  output logic       is_lock_rd
);
  localparam logic [1:0] FMT_LIST [N_FMT] = '{FMT_ND3, FMT_ND4};

  logic [N_FMT-1:0] fmt_hit;

  generate
    for (genvar i = 0; i < N_FMT; i++) begin : g_fmt
      assign fmt_hit[i] = (fmt == FMT_LIST[i]);
    end
  endgenerate

  assign is_lock_rd = (|fmt_hit) && (ttype == TY_MRD_LOCK);
endmodule

// File: rtl/lkur_cpl_form.sv
module lkur_cpl_form
  import lkur_pkg::*;
#(
  parameter int BYTE_CNT = 4
) (
  input  logic [2:0]       tc,
  input  logic [1:0]       attr,
  input  logic [15:0]      rid,
  input  logic [7:0]       tag,
  output logic [HDR_W-1:0] cpl
);
  localparam logic [11:0] BCNT = 12'(BYTE_CNT);

  logic [31:0] w0, w1, w2;

  always_comb begin
    w0 = '0;
    w0[30:29] = FMT_ND3;
    w0[28:24] = TY_CPL_LOCK;
    w0[22:20] = tc;
    w0[13:12] = attr;
    w1 = '0;
    w1[15:13] = STAT_UNSUP;
    w1[11:0]  = BCNT;
    w2 = '0;
    w2[31:16] = rid;
    w2[15:8]  = tag;
  end

  assign cpl = {w0, w1, w2, 32'h0};
endmodule

// File: rtl/lkur_cpl_slot.sv
module lkur_cpl_slot #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_hdr,
  output logic         out_valid,
  input  logic         out_ready,
  output logic [W-1:0] out_hdr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_hdr   <= '0;
    end else if (load) begin
      out_valid <= 1'b1;
      out_hdr   <= load_hdr;
    end else if (out_valid && out_ready) begin
      out_valid <= 1'b0;
    end
  end

  // R6
  cpl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_hdr));

  // R7
  load_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    load |-> !out_valid);
endmodule

// File: rtl/lkur_err_log.sv
module lkur_err_log #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         hit,
  input  logic [W-1:0] hit_hdr,
  output logic         ev_valid,
  output logic [W-1:0] ev_hdr
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_valid <= 1'b0;
      ev_hdr   <= '0;
    end else begin
      ev_valid <= hit;
      if (hit) ev_hdr <= hit_hdr;
    end
  end

  // R8
  err_follows_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ev_valid |-> $past(hit));
endmodule

// File: rtl/lkrd_ur_responder.sv
module lkrd_ur_responder
  import lkur_pkg::*;
#(
  parameter int DATA_W      = 32,
  parameter int UR_BYTE_CNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [HDR_W-1:0]  req_hdr,
  input  logic [DATA_W-1:0] req_data,
  input  logic              req_abort,
  output logic              cpl_valid,
  input  logic              cpl_ready,
  output logic [HDR_W-1:0]  cpl_hdr,
  output logic              fwd_valid,
  input  logic              fwd_ready,
  output logic [HDR_W-1:0]  fwd_hdr,
  output logic [DATA_W-1:0] fwd_data,
  output logic              fwd_abort,
  output logic              err_valid,
  output logic [HDR_W-1:0]  err_hdr
);
  logic             is_lock;
  logic             take_lock;
  logic             pend;
  logic [HDR_W-1:0] cpl_next;

  lkur_classify u_cls (
    .fmt        (req_hdr[P_FMT +: 2]),
    .ttype      (req_hdr[P_TYPE +: 5]),
    .is_lock_rd (is_lock)
  );

  lkur_cpl_form #(.BYTE_CNT(UR_BYTE_CNT)) u_form (
    .tc   (req_hdr[P_TC +: 3]),
    .attr (req_hdr[P_ATTR +: 2]),
    .rid  (req_hdr[P_RID +: 16]),
    .tag  (req_hdr[P_TAG +: 8]),
    .cpl  (cpl_next)
  );

  assign pend      = cpl_valid;
  assign req_ready = !pend && (is_lock || fwd_ready);
  assign fwd_valid = req_valid && !is_lock && !pend;
  assign fwd_hdr   = req_hdr;
  assign fwd_data  = req_data;
  assign fwd_abort = req_abort;
  assign take_lock = req_valid && req_ready && is_lock;

  lkur_cpl_slot #(.W(HDR_W)) u_slot (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (take_lock && !req_abort),
    .load_hdr  (cpl_next),
    .out_valid (cpl_valid),
    .out_ready (cpl_ready),
    .out_hdr   (cpl_hdr)
  );

  lkur_err_log #(.W(HDR_W)) u_log (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit      (take_lock),
    .hit_hdr  (req_hdr),
    .ev_valid (err_valid),
    .ev_hdr   (err_hdr)
  );

  // R7
  stall_on_pend_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> !req_ready && !fwd_valid);

  // R8
  cpl_logged_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpl_valid) |-> err_valid && !$past(req_abort));

  // R4
  cpl_ur_status_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cpl_valid |-> cpl_hdr[P_STAT +: 3] == STAT_UNSUP &&
                  cpl_hdr[P_LEN +: 10] == 10'd0 &&
                  cpl_hdr[P_BCNT +: 12] == 12'(UR_BYTE_CNT));

  // R9
  abort_no_cpl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_abort |=> !$rose(cpl_valid));
endmodule

// File: tb/lkrd_ur_responder_test.sv
module lkrd_ur_responder_test;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         req_valid = 1'b0;
  logic         req_ready;
  logic [127:0] req_hdr = '0;
  logic [31:0]  req_data = '0;
  logic         req_abort = 1'b0;
  logic         cpl_valid;
  logic         cpl_ready = 1'b1;
  logic [127:0] cpl_hdr;
  logic         fwd_valid;
  logic         fwd_ready = 1'b1;
  logic [127:0] fwd_hdr;
  logic [31:0]  fwd_data;
  logic         fwd_abort;
  logic         err_valid;
  logic [127:0] err_hdr;

  int n_chk = 0;
  int n_bad = 0;
  int mode = 0;
  int cyc = 0;

  always #2.5 clk = ~clk;

  lkrd_ur_responder uut (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready), .req_hdr(req_hdr),
    .req_data(req_data), .req_abort(req_abort),
    .cpl_valid(cpl_valid), .cpl_ready(cpl_ready), .cpl_hdr(cpl_hdr),
    .fwd_valid(fwd_valid), .fwd_ready(fwd_ready), .fwd_hdr(fwd_hdr),
    .fwd_data(fwd_data), .fwd_abort(fwd_abort),
    .err_valid(err_valid), .err_hdr(err_hdr)
  );

  function automatic logic lock_rd(input logic [127:0] h);
    logic [31:0] d0;
    d0 = h[127:96];
    return (d0[30:29] == 2'b00 || d0[30:29] == 2'b01) && d0[28:24] == 5'b00001;
  endfunction

  function automatic logic [127:0] exp_cpl(input logic [127:0] h);
    logic [31:0] a, b, c, q;
    q = h[95:64];
    a = '0; a[28:24] = 5'b01011; a[22:20] = h[118:116]; a[13:12] = h[109:108];
    b = '0; b[15:13] = 3'b001; b[11:0] = 12'd4;
    c = '0; c[31:16] = q[31:16]; c[15:8] = q[15:8];
    return {a, b, c, 32'h0};
  endfunction

  function automatic logic [127:0] mk_req(input logic [1:0] fmt, input logic [4:0] ty,
      input logic [2:0] tc, input logic td, input logic ep, input logic [1:0] attr,
      input logic [9:0] len, input logic [15:0] rid, input logic [7:0] tag,
      input logic [7:0] be, input logic [31:0] ahi, input logic [31:0] alo);
    logic [31:0] a, b;
    a = '0; a[30:29] = fmt; a[28:24] = ty; a[22:20] = tc; a[15] = td; a[14] = ep;
    a[13:12] = attr; a[9:0] = len;
    b = {rid, tag, be};
    if (fmt[0]) return {a, b, ahi, alo & 32'hFFFF_FFFC};
    return {a, b, alo & 32'hFFFF_FFFC, 32'h0};
  endfunction

  task automatic chk(input string tag, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference model
  logic         m_pend = 1'b0;
  logic [127:0] m_cpl = '0;
  logic         m_errv = 1'b0;
  logic [127:0] m_errh = '0;
  logic         m_ready;

  always_comb m_ready = !m_pend && (lock_rd(req_hdr) || fwd_ready);

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pend <= 1'b0;
      m_errv <= 1'b0;
    end else begin
      m_errv <= req_valid && m_ready && lock_rd(req_hdr);
      if (req_valid && m_ready && lock_rd(req_hdr)) m_errh <= req_hdr;
      if (req_valid && m_ready && lock_rd(req_hdr) && !req_abort) begin
        m_pend <= 1'b1;
        m_cpl  <= exp_cpl(req_hdr);
      end else if (m_pend && cpl_ready) begin
        m_pend <= 1'b0;
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      chk("R7 req_ready", {127'b0, req_ready}, {127'b0, m_ready});
      chk("R2 R7 fwd_valid", {127'b0, fwd_valid},
          {127'b0, req_valid && !lock_rd(req_hdr) && !m_pend});
      if (fwd_valid)
        chk("R2 fwd payload", {fwd_hdr[127:33], fwd_data, fwd_abort},
            {req_hdr[127:33], req_data, req_abort});
      chk("R6 R9 cpl_valid", {127'b0, cpl_valid}, {127'b0, m_pend});
      if (cpl_valid && m_pend) begin
        chk("R3 cpl dw0", {96'b0, cpl_hdr[127:96]}, {96'b0, m_cpl[127:96]});
        chk("R4 cpl dw1", {96'b0, cpl_hdr[95:64]}, {96'b0, m_cpl[95:64]});
        chk("R5 cpl dw2 dw3", {64'b0, cpl_hdr[63:0]}, {64'b0, m_cpl[63:0]});
      end
      chk("R8 R9 err_valid", {127'b0, err_valid}, {127'b0, m_errv});
      if (err_valid && m_errv) chk("R8 err_hdr", err_hdr, m_errh);
    end
  end

  // output-side back-pressure
  initial begin
    forever begin
      @(posedge clk); #1;
      case (mode)
        0: begin cpl_ready = 1'b1; fwd_ready = 1'b1; end
        1: begin cpl_ready = 1'b0; fwd_ready = 1'b1; end
        default: begin cpl_ready = $urandom_range(0, 1) == 1; fwd_ready = $urandom_range(0, 2) != 0; end
      endcase
    end
  end

  task automatic send(input logic [127:0] h, input logic [31:0] d, input logic ab);
    logic took;
    @(posedge clk); #1;
    req_valid = 1'b1; req_hdr = h; req_data = d; req_abort = ab;
    forever begin
      @(negedge clk);
      took = req_ready;
      @(posedge clk);
      if (took) break;
    end
    #1 req_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    idle(3);
    @(negedge clk);
    // R1
    chk("R1 cpl_valid in reset", {127'b0, cpl_valid}, 128'b0);
    chk("R1 err_valid in reset", {127'b0, err_valid}, 128'b0);
    @(posedge clk); #1 rst_n = 1'b1;

    // R3 R4 R5: 3-dword locked read with TD/EP set and long length
    send(mk_req(2'b00, 5'b00001, 3'd5, 1, 1, 2'b10, 10'd1023, 16'hA5C3, 8'h3C, 8'hF1, 0, 32'h1234_5677), 32'h11, 0);
    idle(3);
    // 4-dword locked read, different enables and upper address
    send(mk_req(2'b01, 5'b00001, 3'd2, 0, 0, 2'b01, 10'd0, 16'h0F0F, 8'hC2, 8'h7E, 32'hDEAD_BEEF, 32'hFFFF_FFFF), 32'h22, 0);
    idle(3);
    // R9: aborted locked read
    send(mk_req(2'b01, 5'b00001, 3'd7, 1, 0, 2'b11, 10'd4, 16'h8001, 8'h01, 8'h11, 32'h1, 32'h40), 32'h33, 1);
    idle(3);
    // R2: near misses forwarded
    send(mk_req(2'b10, 5'b00001, 3'd1, 0, 0, 2'b00, 10'd8, 16'h1111, 8'h22, 8'hFF, 0, 32'h80), 32'h44, 0);
    send(mk_req(2'b00, 5'b00000, 3'd1, 0, 0, 2'b00, 10'd8, 16'h2222, 8'h33, 8'hFF, 0, 32'h90), 32'h55, 0);
    send(mk_req(2'b11, 5'b00000, 3'd3, 0, 1, 2'b01, 10'd2, 16'h3333, 8'h44, 8'hFF, 32'h9, 32'hA0), 32'h66, 1);
    idle(3);

    // R6 R7: completion stalled while a forward header waits behind it
    mode = 1;
    fork
      begin
        send(mk_req(2'b00, 5'b00001, 3'd4, 0, 0, 2'b11, 10'd16, 16'h7777, 8'h99, 8'hFF, 0, 32'h100), 32'h77, 0);
        send(mk_req(2'b10, 5'b00000, 3'd0, 0, 0, 2'b00, 10'd1, 16'h4444, 8'h55, 8'h0F, 0, 32'h200), 32'h88, 0);
      end
      begin idle(12); mode = 0; end
    join
    idle(4);

    // random mix under random back-pressure
    mode = 2;
    for (int i = 0; i < 400; i++) begin
      logic [1:0] f;
      logic [4:0] t;
      f = 2'($urandom_range(0, 3));
      t = ($urandom_range(0, 1) == 1) ? 5'b00001 : 5'($urandom_range(0, 31));
      send(mk_req(f, t, 3'($urandom), 1'($urandom), 1'($urandom), 2'($urandom),
                  10'($urandom), 16'($urandom), 8'($urandom), 8'($urandom),
                  $urandom, $urandom), $urandom, $urandom_range(0, 4) == 0);
    end
    mode = 0;
    idle(6);
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 150000) begin
        n_chk++; n_bad++;
        $display("FAIL watchdog act=%0d exp=<150000", cyc);
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
      end
    end
  end
endmodule